// File: doc/BRIEF.md
# Rank and DRAM Address Mapper

This block takes an address that is already local to one memory channel and resolves it into a DIMM number, a rank within that DIMM, and the DRAM row, column, bank address and bank group. A pulse on `start` captures the channel address. The controller then scans up to four programmable rank-range entries, one per cycle, until it finds the range that holds the address. It removes the rank interleave, subtracts a per-rank offset, and scatters the resulting rank address into the DRAM coordinates through fixed bit-position lists. Which lists apply depends on the page policy.

All settings are written through a simple register port before a lookup starts. The port holds the range words, eight interleave words per range (one for each possible interleave index), and one settings word for each of the four DIMMs. The result is presented with a one-cycle `done` pulse. If no range matches, `done` comes with `err` and the outputs are zero.

The controller has four states. `S_IDLE` waits for `start`. `S_SCAN` tests one range per cycle; it goes to `S_RANK` on a match, back to `S_IDLE` with an error after the last range, and otherwise stays. `S_RANK` computes the rank address and channel rank and always goes to `S_MAP`. `S_MAP` registers the DRAM coordinates, pulses `done` and returns to `S_IDLE`.

Top module: `rank_dram_mapper`

## Requirements
- R1: After reset, `done`, `err`, `dimm`, `rank`, `row`, `col`, `bank` and `bgrp` are all zero.
- R2: A range word has these fields: bit 31 = valid, bits 29:28 = w (ways = 2^w), and bits 11:1 = L (limit = L·2^29 + 2^29 − 1). Range i matches when it is valid and prev ≤ addr ≤ limit. Here prev is 0 for range 0, and for every later range it is the limit of the range before it, without adding one, whether or not that earlier range is valid. The lowest matching index wins.
- R3: When no range matches, `done` and `err` are both 1 for one cycle, and `dimm`, `rank`, `row`, `col`, `bank` and `bgrp` are 0.
- R4: The interleave shift s is 6 when DIMM 0 is set to closed page, and 13 otherwise. The rank address is ((addr>>s)>>w)<<s OR (addr mod 2^s). The interleave index is (addr>>s) mod 2^w. With w = 0 the index is 0 and the address above bit s is unchanged.
- R5: The index picks the matched range's interleave word. Its bits 15:2, shifted up by 26, are subtracted from the rank address. Its bits 19:16 are the channel rank c, with `dimm` = c/4 and `rank` = c mod 4. The page policy used for the DRAM mapping comes from DIMM `dimm`'s settings.
- R6: In closed page, row bit i comes from rank-address bit 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33,34 (i = 0 upward). Column bit i comes from bit 3,4,5,14,19,23,24,25,26,27. `col[10]` is always 1.
- R7: In open page, row bit i comes from bit 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33,34. Column bit i comes from bit 3+i, or from bit 3,4,5,7,8,9,10,11,12,13 when fine-grain bank is set. `col[10]` is 0.
- R8: With hashing off, the bank/bank group are {b9,b8}/{b7,b6} in closed page. In open page they are {b19,b18}/{b17,bg}, where bg is b6 with fine-grain bank and b13 without.
- R9: With hashing on, the bank is XORed with {b28,b22} in closed page or with {b23,b22} in open page. The bank group is XORed with {b21,b20} in both policies.
- R10: Row bits at or above the configured row width and column bits 9:0 at or above the configured column width are 0.
- R11: Register port select values: 0–3 are the range words; 4+8·e+k is the interleave word for index k of range e; 36+d is DIMM d's settings word. In a settings word, bit 0 = closed page, bit 1 = fine-grain bank, bit 2 = XOR hashing, bits 12:8 = row width, and bits 19:16 = column width.
- R12: `done` is a one-cycle pulse. It is high k+3 cycles after the edge that samples `start` for a match in range k, and NUM_RANGES cycles after that edge for an error. A `start` while a lookup is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a lookup of `chan_addr` |
| chan_addr | input | ADDR_W | Channel-local address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | 32 | Register write data |
| done | output | 1 | Result valid pulse |
| err | output | 1 | No range matched (with `done`) |
| dimm | output | 2 | DIMM number |
| rank | output | 2 | Rank within the DIMM |
| row | output | 18 | DRAM row |
| col | output | 11 | DRAM column, bit 10 = autoprecharge |
| bank | output | 2 | Bank address |
| bgrp | output | 2 | Bank group |

## Verification
On every cycle, the assertions check that `done` never lasts longer than one cycle, that `err` only comes with `done`, and that an unmatched last range leads straight to an error pulse. They also check that `S_RANK` is only ever entered from `S_SCAN`, that every result honours the row-width mask, and that the autoprecharge column bit follows the selected DIMM's page policy. Only the bench's scenarios can show the correct bit gathering for each page policy, fine-grain and hashing setting. The same holds for range chaining through an invalid entry with an inclusive previous limit, the offset subtraction, the per-range latency, and a second `start` being ignored.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    localparam int ROW_MAX  = 18;
    localparam int COL_MAX  = 10;
    localparam int DIMMS    = 4;
    localparam int MAX_WAYS = 8;

    // Source bit positions in the rank address, indexed by output bit
    localparam int CLOSED_ROW [ROW_MAX] = '{15, 16, 17, 18, 20, 21, 22, 28, 10,
                                            11, 12, 13, 29, 30, 31, 32, 33, 34};
    localparam int OPEN_ROW   [ROW_MAX] = '{14, 15, 16, 20, 28, 21, 22, 23, 24,
                                            25, 26, 27, 29, 30, 31, 32, 33, 34};
    localparam int CLOSED_COL [COL_MAX] = '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
    localparam int OPEN_COL   [COL_MAX] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    localparam int FINE_COL   [COL_MAX] = '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};

    typedef struct packed {
        logic [4:0] row_w;
        logic [3:0] col_w;
        logic       xor_en;
        logic       fine;
        logic       closed;
    } dimm_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_RANK,
        S_MAP
    } map_state_t;

endpackage

// File: rtl/rdm_regs.sv
module rdm_regs
    import rdm_pkg::*;
#(
    parameter int NUM_RANGES = 4,
    parameter int SEL_W      = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [SEL_W-1:0]                       sel,
    input  logic [31:0]                            wdata,
    output logic [NUM_RANGES-1:0][31:0]            range_words,
    output logic [NUM_RANGES*MAX_WAYS-1:0][31:0]   ilv_words,
    output dimm_cfg_t [DIMMS-1:0]                  dimm_cfg
);
    localparam int ILV_BASE  = NUM_RANGES;
    localparam int ILV_NUM   = NUM_RANGES * MAX_WAYS;
    localparam int DIMM_BASE = ILV_BASE + ILV_NUM;

    logic [DIMMS-1:0][31:0] dimm_words;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           range_words[g] <= '0;
            else if (we && sel == SEL_W'(g))      range_words[g] <= wdata;
        end
    end

    for (genvar g = 0; g < ILV_NUM; g++) begin : g_ilv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 ilv_words[g] <= '0;
            else if (we && sel == SEL_W'(ILV_BASE + g)) ilv_words[g] <= wdata;
        end
    end

    logic unused_dimm_bits;
    logic [DIMMS-1:0] unused_vec;

    for (genvar g = 0; g < DIMMS; g++) begin : g_dimm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  dimm_words[g] <= '0;
            else if (we && sel == SEL_W'(DIMM_BASE + g)) dimm_words[g] <= wdata;
        end
        assign dimm_cfg[g].closed = dimm_words[g][0];
        assign dimm_cfg[g].fine   = dimm_words[g][1];
        assign dimm_cfg[g].xor_en = dimm_words[g][2];
        assign dimm_cfg[g].row_w  = dimm_words[g][12:8];
        assign dimm_cfg[g].col_w  = dimm_words[g][19:16];
        assign unused_vec[g] = ^{dimm_words[g][31:20], dimm_words[g][15:13],
                                 dimm_words[g][7:3]};
    end

    assign unused_dimm_bits = ^unused_vec;

endmodule

// File: rtl/rdm_scatter.sv
module rdm_scatter
    import rdm_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]  rank_addr,
    input  dimm_cfg_t          cfg,
    output logic [ROW_MAX-1:0] row,
    output logic [COL_MAX:0]   col,
    output logic [1:0]         bank,
    output logic [1:0]         bgrp
);
    logic [ROW_MAX-1:0] row_c, row_o;
    logic [COL_MAX-1:0] col_c, col_o, col_f;

    for (genvar i = 0; i < ROW_MAX; i++) begin : g_row
        assign row_c[i] = rank_addr[CLOSED_ROW[i]];
        assign row_o[i] = rank_addr[OPEN_ROW[i]];
    end

    for (genvar i = 0; i < COL_MAX; i++) begin : g_col
        assign col_c[i] = rank_addr[CLOSED_COL[i]];
        assign col_o[i] = rank_addr[OPEN_COL[i]];
        assign col_f[i] = rank_addr[FINE_COL[i]];
    end

    logic [ROW_MAX-1:0] row_raw;
    logic [COL_MAX-1:0] col_raw;
    logic [1:0]         bank_raw, bank_hash, bg_raw;

    always_comb begin
        if (cfg.closed) begin
            row_raw   = row_c;
            col_raw   = col_c;
            bank_raw  = {rank_addr[9], rank_addr[8]};
            bg_raw    = {rank_addr[7], rank_addr[6]};
            bank_hash = {rank_addr[28], rank_addr[22]};
        end else begin
            row_raw   = row_o;
            col_raw   = cfg.fine ? col_f : col_o;
            bank_raw  = {rank_addr[19], rank_addr[18]};
            bg_raw    = {rank_addr[17], cfg.fine ? rank_addr[6] : rank_addr[13]};
            bank_hash = {rank_addr[23], rank_addr[22]};
        end
        for (int i = 0; i < ROW_MAX; i++)
            row[i] = row_raw[i] & (5'(i) < cfg.row_w);
        for (int i = 0; i < COL_MAX; i++)
            col[i] = col_raw[i] & (4'(i) < cfg.col_w);
        col[COL_MAX] = cfg.closed;
        bank = bank_raw ^ (cfg.xor_en ? bank_hash : 2'b00);
        bgrp = bg_raw ^ (cfg.xor_en ? {rank_addr[21], rank_addr[20]} : 2'b00);
    end

endmodule

// File: rtl/rank_dram_mapper.sv
module rank_dram_mapper
    import rdm_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4,
    localparam int SEL_W     = $clog2(NUM_RANGES * (1 + MAX_WAYS) + DIMMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  chan_addr,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic               done,
    output logic               err,
    output logic [1:0]         dimm,
    output logic [1:0]         rank,
    output logic [17:0]        row,
    output logic [10:0]        col,
    output logic [1:0]         bank,
    output logic [1:0]         bgrp
);
    localparam int IDX_W = $clog2(NUM_RANGES);
    localparam int WAY_W = $clog2(MAX_WAYS);

    logic [NUM_RANGES-1:0][31:0]          range_words;
    logic [NUM_RANGES*MAX_WAYS-1:0][31:0] ilv_words;
    dimm_cfg_t [DIMMS-1:0]                dimm_cfg;

    rdm_regs #(.NUM_RANGES(NUM_RANGES), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .range_words(range_words), .ilv_words(ilv_words), .dimm_cfg(dimm_cfg)
    );

    map_state_t          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [ADDR_W-1:0]   addr_q, prev_q, rank_addr_q;
    logic [3:0]          crank_q;

    // Current range entry
    logic [31:0]         cur;
    logic [ADDR_W-1:0]   cur_limit;
    logic [1:0]          cur_w;
    logic                hit, last;

    assign cur       = range_words[idx_q];
    assign cur_w     = cur[29:28];
    assign cur_limit = ADDR_W'({cur[11:1], 29'h1FFF_FFFF});
    assign hit       = cur[31] && (prev_q <= addr_q) && (addr_q <= cur_limit);
    assign last      = (idx_q == IDX_W'(NUM_RANGES - 1));

    // Rank interleave removal and offset
    logic                closed0;
    logic [ADDR_W-1:0]   q_sh, low_bits, rank_calc;
    logic [WAY_W-1:0]    way_idx;
    logic [31:0]         ilv_w;
    logic                unused_ok;

    always_comb begin
        closed0   = dimm_cfg[0].closed;
        q_sh      = closed0 ? (addr_q >> 6) : (addr_q >> 13);
        low_bits  = addr_q & (closed0 ? ADDR_W'(63) : ADDR_W'(8191));
        way_idx   = q_sh[WAY_W-1:0] & WAY_W'((1 << cur_w) - 1);
        ilv_w     = ilv_words[{idx_q, way_idx}];
        rank_calc = (closed0 ? ((q_sh >> cur_w) << 6) : ((q_sh >> cur_w) << 13)) | low_bits;
        rank_calc = rank_calc - (ADDR_W'(ilv_w[15:2]) << 26);
    end

    assign unused_ok = ^{ilv_w[31:20], ilv_w[1:0], cur[30], cur[27:12], cur[0]};

    logic [ROW_MAX-1:0] map_row;
    logic [COL_MAX:0]   map_col;
    logic [1:0]         map_bank, map_bg;

    rdm_scatter #(.ADDR_W(ADDR_W)) scatter_i (
        .rank_addr(rank_addr_q), .cfg(dimm_cfg[crank_q[3:2]]),
        .row(map_row), .col(map_col), .bank(map_bank), .bgrp(map_bg)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_SCAN;
            S_SCAN: if (hit) state_d = S_RANK;
                    else if (last) state_d = S_IDLE;
            S_RANK: state_d = S_MAP;
            S_MAP:  state_d = S_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; addr_q <= '0; prev_q <= '0; rank_addr_q <= '0; crank_q <= '0;
            done <= 1'b0; err <= 1'b0; dimm <= '0; rank <= '0;
            row <= '0; col <= '0; bank <= '0; bgrp <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    addr_q <= chan_addr;
                    idx_q  <= '0;
                    prev_q <= '0;
                end
                S_SCAN: if (!hit) begin
                    prev_q <= cur_limit;
                    idx_q  <= idx_q + 1'b1;
                    if (last) begin
                        done <= 1'b1; err <= 1'b1;
                        dimm <= '0; rank <= '0; row <= '0; col <= '0; bank <= '0; bgrp <= '0;
                    end
                end
                S_RANK: begin
                    rank_addr_q <= rank_calc;
                    crank_q     <= ilv_w[19:16];
                end
                S_MAP: begin
                    done <= 1'b1;
                    dimm <= crank_q[3:2];
                    rank <= crank_q[1:0];
                    row  <= map_row;
                    col  <= map_col;
                    bank <= map_bank;
                    bgrp <= map_bg;
                end
            endcase
        end
    end

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_miss_to_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && !hit && last) |=> (done && err));

    assert_rank_after_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RANK) |-> ($past(state_q) == S_SCAN));

    assert_row_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((row >> dimm_cfg[dimm].row_w) == '0));

    assert_autopre_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (col[10] == dimm_cfg[dimm].closed));

endmodule

// File: tb/rank_dram_mapper_tb_top.sv
module rank_dram_mapper_tb_top;

    localparam int AW = 40;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] chan_addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        done, err;
    logic [1:0]  dimm, rank, bank, bgrp;
    logic [17:0] row;
    logic [10:0] col;

    always #5 clk = ~clk;

    rank_dram_mapper #(.ADDR_W(AW), .NUM_RANGES(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_addr(chan_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .done(done), .err(err), .dimm(dimm), .rank(rank),
        .row(row), .col(col), .bank(bank), .bgrp(bgrp)
    );

    int tests = 0;
    int fails = 0;

    // Range setup: valid, log2 ways, limit field
    localparam int RV [4] = '{1, 0, 1, 1};
    localparam int RW [4] = '{0, 0, 2, 1};
    localparam int RL [4] = '{1, 2, 3, 7};

    localparam int B_CROW [18] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33,34};
    localparam int B_OROW [18] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33,34};
    localparam int B_CCOL [10] = '{3,4,5,14,19,23,24,25,26,27};
    localparam int B_OCOL [10] = '{3,4,5,6,7,8,9,10,11,12};
    localparam int B_FCOL [10] = '{3,4,5,7,8,9,10,11,12,13};

    // Stimulus: {address, settings word applied to every DIMM}
    localparam logic [71:0] VEC [12] = '{
        {40'h00_1234_5678, 32'h000A1201},
        {40'h00_3FFF_FFFF, 32'h000A1201},
        {40'h00_5FFF_FFFF, 32'h000A1200},
        {40'h00_6ABC_DEF0, 32'h000A1202},
        {40'h00_7FFF_FFC0, 32'h000A1205},
        {40'h00_9876_5432, 32'h000A1204},
        {40'h00_F0F0_A5A5, 32'h00080E01},
        {40'h00_C3C3_3C3C, 32'h00090F06},
        {40'h00_5000_0000, 32'h000A1201},
        {40'h01_0000_0000, 32'h000A1200},
        {40'h00_2AAA_5555, 32'h000A1204},
        {40'h00_7123_4567, 32'h000A1205}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R11: register port write
    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 6'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_dimms(input logic [31:0] w);
        for (int d = 0; d < 4; d++) wr(36 + d, w);
    endtask

    task automatic run(input logic [AW-1:0] a, output int cyc);
        @(negedge clk);
        chan_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic int crank_of(input int e, input int k);
        return (e * 5 + k) & 15;
    endfunction

    task automatic model(input logic [AW-1:0] a, input logic [31:0] cw,
                         output logic e, output int hit_at, output logic [1:0] md, mr,
                         output logic [17:0] mrow, output logic [10:0] mcol,
                         output logic [1:0] mb, mg);
        logic [AW-1:0] prev, lim, q, ra;
        int f, sh, k, c;
        logic closed, fine, xr;
        f = -1; prev = '0;
        for (int i = 0; i < 4; i++) begin
            lim = (AW'(RL[i]) << 29) | AW'(32'h1FFF_FFFF);
            if (f < 0 && RV[i] == 1 && prev <= a && a <= lim) f = i;
            if (f < 0) prev = lim;
        end
        e = (f < 0); hit_at = f;
        md = '0; mr = '0; mrow = '0; mcol = '0; mb = '0; mg = '0;
        if (f >= 0) begin
            closed = cw[0]; fine = cw[1]; xr = cw[2];
            sh = closed ? 6 : 13;
            q = a >> sh;
            k = int'(q) & ((1 << RW[f]) - 1);
            ra = ((q >> RW[f]) << sh) | (a & ((AW'(1) << sh) - 1));
            ra = ra - (AW'(f) << 26);
            c = crank_of(f, k);
            md = 2'(c / 4); mr = 2'(c % 4);
            for (int i = 0; i < 18; i++)
                if (i < int'(cw[12:8])) mrow[i] = ra[closed ? B_CROW[i] : B_OROW[i]];
            for (int i = 0; i < 10; i++)
                if (i < int'(cw[19:16]))
                    mcol[i] = ra[closed ? B_CCOL[i] : (fine ? B_FCOL[i] : B_OCOL[i])];
            mcol[10] = closed;
            if (closed) begin
                mb = {ra[9], ra[8]};   mg = {ra[7], ra[6]};
                if (xr) mb = mb ^ {ra[28], ra[22]};
            end else begin
                mb = {ra[19], ra[18]}; mg = {ra[17], fine ? ra[6] : ra[13]};
                if (xr) mb = mb ^ {ra[23], ra[22]};
            end
            if (xr) mg = mg ^ {ra[21], ra[20]};
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc, hit_at, n_done;
        logic e;
        logic [1:0] md, mr, mb, mg;
        logic [17:0] mrow;
        logic [10:0] mcol;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {done, err, dimm, rank, row, col, bank, bgrp}, '0);
        rst_n = 1'b1;

        // R11 programming: ranges, interleave words, DIMM settings
        for (int i = 0; i < 4; i++)
            wr(i, (32'(RV[i]) << 31) | (32'(RW[i]) << 28) | (32'(RL[i]) << 1));
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 8; k++)
                wr(4 + i * 8 + k, (32'(crank_of(i, k)) << 16) | (32'(i) << 2));

        // R6 R11: hand-computed zero address in closed page
        set_dimms(32'h000A1201);
        run('0, cyc);
        chk("R6 R11 zero address column", {52'h0, col}, 64'h400);
        chk("R5 zero address rank", {dimm, rank, row, err}, '0);

        // Table walk
        for (int v = 0; v < 12; v++) begin
            set_dimms(VEC[v][31:0]);
            model(VEC[v][71:32], VEC[v][31:0], e, hit_at, md, mr, mrow, mcol, mb, mg);
            run(VEC[v][71:32], cyc);
            chk("R2 R3 match or error", {done, err}, {1'b1, e});
            chk("R12 latency", 64'(cyc), e ? 64'(NR + 1) : 64'(hit_at + 4));
            chk("R4 R5 dimm and rank", {dimm, rank}, {md, mr});
            chk("R6 R7 R10 row", 64'(row), 64'(mrow));
            chk("R6 R7 R10 column", 64'(col), 64'(mcol));
            chk(VEC[v][2] ? "R9 hashed bank" : "R8 bank", {bank, bgrp}, {mb, mg});
        end

        // R12: second start during a lookup is ignored, single done pulse
        set_dimms(32'h000A1200);
        @(negedge clk);
        chan_addr = 40'h00_F000_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chan_addr = 40'h00_0000_0040; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_done = 0;
        for (int c = 0; c < 30; c++) begin
            if (done) n_done++;
            @(negedge clk);
        end
        chk("R12 one done for overlapping start", 64'(n_done), 64'd1);

        // R3: error outputs cleared after a successful lookup
        set_dimms(32'h000A1201);
        run(40'h00_3000_0000, cyc);
        run(40'h01_2345_6789, cyc);
        chk("R3 error clears outputs", {err, dimm, rank, row, col, bank, bgrp},
            {1'b1, 37'h0});
        @(negedge clk);
        chk("R12 done drops", {62'h0, done, err}, '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule